// File: doc/BRIEF.md
# ATM Cell Transmission Convergence Framer

This block sits between an octet-wide line interface and the ATM layer. In the receive direction it takes an octet stream with no cell alignment. It finds where cells begin by testing the header check octet, and it removes cells whose header fails the check as well as idle (null) cells. Every remaining cell goes up to the ATM layer as 53 octets, with a strobe on the first octet. A three-state delineation machine (searching, confirming, locked) decides when the boundary is trusted. The block delivers nothing until the lock is reached, and a status output shows the lock.

In the transmit direction the line interface gives one octet slot per enable pulse. The framer fills every 53-octet slot with a whole cell. If the ATM layer has a complete cell waiting when a slot begins, the framer reads its four header octets and 48 payload octets, and it computes the header check octet and inserts it. If no cell is waiting, the slot carries a null cell. Line framing, scrambling and clock recovery belong to other blocks.

Top module: `atm_tc_framer`

## Requirements
- R1: After reset `rx_in_sync` is 0 and `rx_cell_valid` is 0, and the receiver is searching for a boundary.
- R2: The header check octet is the CRC-8 with generator x^8+x^2+x+1 (zero initial value, first header octet first, most significant bit first) over the first four header octets, XORed with 0x55, and it is the fifth octet. While searching, the receiver tests every octet offset and locks at the first octet equal to the check of the four octets before it.
- R3: After a lock, the receiver tests the header check once every 53 valid octets. `rx_in_sync` rises after 6 further consecutive correct checks, and not earlier.
- R4: A single incorrect check while confirming returns the receiver to searching, and the count of correct checks starts again.
- R5: While locked, up to 6 consecutive incorrect checks keep `rx_in_sync` at 1. The 7th consecutive incorrect check drops it to 0. A correct check clears the run.
- R6: While locked, a cell whose header check is incorrect is not delivered.
- R7: A cell whose first four header octets are 0x00,0x00,0x00,0x01 is a null cell and is not delivered.
- R8: A delivered cell leaves on `rx_cell_data` as all 53 octets, header check included, in arrival order. `rx_cell_soc` is set on the first octet only. One output octet follows each accepted input octet, with a delay of five valid input octets.
- R9: A cell is delivered only when the receiver was locked at the time its header check octet arrived. No octet is delivered while searching or confirming.
- R10: A transmit slot for which no complete cell was offered at the slot's first octet carries 0x00,0x00,0x00,0x01,0x52 followed by 48 octets of 0x6A.
- R11: A transmit slot that starts with `atm_tx_avail` high carries the ATM layer's four header octets, then the computed check octet, then its 48 payload octets. `atm_tx_rd` pulses exactly once for each of those 52 octets.
- R12: A cell that becomes available after a slot has begun does not interrupt that slot. It is sent in the next slot.
- R13: Each `tx_octet_en` pulse produces exactly one `tx_line_valid` octet, one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in_valid | input | 1 | Receive line octet present |
| rx_in_data | input | 8 | Receive line octet |
| rx_cell_valid | output | 1 | Delivered cell octet present |
| rx_cell_data | output | 8 | Delivered cell octet |
| rx_cell_soc | output | 1 | First octet of a delivered cell |
| rx_in_sync | output | 1 | Receiver locked to cell boundaries |
| tx_octet_en | input | 1 | Line requests one transmit octet |
| atm_tx_avail | input | 1 | ATM layer holds a complete cell |
| atm_tx_data | input | 8 | Current ATM layer octet (header octets 0-3, then payload) |
| atm_tx_rd | output | 1 | Advance the ATM layer to its next octet |
| tx_line_valid | output | 1 | Transmit line octet present |
| tx_line_data | output | 8 | Transmit line octet |

## Verification
If the receive octet position drifted, or if the hysteresis counter were wrong, `rx_in_sync` would rise or fall one cell early or late. The bench therefore samples it after every cell across the confirmation and loss windows. A wrong emission counter, or a bad null or check decision, appears within one cell: an octet arrives on `rx_cell_data` with no scoreboard entry, or it differs from the expected entry. On transmit, a wrong slot position or a stale slot-owner flag corrupts the very next line octets. This shows up as a wrong header, a wrong check octet or a wrong fill octet, and as a read count that does not match the cells offered.

// File: rtl/atm_tc_pkg.sv
package atm_tc_pkg;

    localparam int          HDR_OCTETS = 5;
    localparam int          HEC_POS    = HDR_OCTETS - 1;
    localparam logic [31:0] NULL_HDR   = 32'h0000_0001;
    localparam logic [7:0]  HEC_POLY   = 8'h07;

    typedef enum logic [1:0] {
        DL_HUNT    = 2'd0,
        DL_PRESYNC = 2'd1,
        DL_SYNC    = 2'd2
    } delin_e;

    // one octet of the header CRC, most significant bit first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] octet);
        logic [7:0] c;
        c = crc_in ^ octet;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ HEC_POLY) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [7:0] hec_of(input logic [31:0] hdr, input logic [7:0] coset);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 4; i++) begin
            c = crc8_step(c, hdr[8*(3-i) +: 8]);
        end
        return c ^ coset;
    endfunction

endpackage

// File: rtl/atm_tc_rx.sv
module atm_tc_rx
    import atm_tc_pkg::*;
#(
    parameter int          CELL_LEN     = 53,
    parameter int          PRESYNC_GOOD = 6,
    parameter int          SYNC_BAD     = 7,
    parameter logic [7:0]  HEC_COSET    = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       cell_valid,
    output logic [7:0] cell_data,
    output logic       cell_soc,
    output logic       in_sync
);

    localparam int POS_W = $clog2(CELL_LEN);
    localparam int REM_W = $clog2(CELL_LEN + 1);
    localparam int MAX_C = (PRESYNC_GOOD > SYNC_BAD) ? PRESYNC_GOOD : SYNC_BAD;
    localparam int CNT_W = $clog2(MAX_C + 1);

    typedef struct packed {
        delin_e                         st;
        logic [POS_W-1:0]               pos;
        logic [CNT_W-1:0]               cnt;
        logic [HDR_OCTETS-1:0][7:0]     win;
        logic [REM_W-1:0]               rem;
        logic                           ov;
        logic [7:0]                     od;
        logic                           os;
    } rx_state_t;

    rx_state_t   q, n;
    logic [31:0] hdr_word;
    logic        hec_ok;
    logic        is_null;
    logic        at_hec;

    always_comb begin
        hdr_word = {q.win[3], q.win[2], q.win[1], q.win[0]};
        hec_ok   = (hec_of(hdr_word, HEC_COSET) == in_data);
        is_null  = (hdr_word == NULL_HDR);
        at_hec   = (q.pos == POS_W'(HEC_POS));

        n    = q;
        n.ov = 1'b0;
        n.os = 1'b0;
        if (in_valid) begin
            n.win = {q.win[HDR_OCTETS-2:0], in_data};
            n.pos = (q.pos == POS_W'(CELL_LEN - 1)) ? '0 : q.pos + 1'b1;
            if (q.rem != '0) begin
                n.ov  = 1'b1;
                n.od  = q.win[HDR_OCTETS-1];
                n.os  = (q.rem == REM_W'(CELL_LEN));
                n.rem = q.rem - 1'b1;
            end
            case (q.st)
                DL_HUNT: begin
                    if (hec_ok) begin
                        n.st  = DL_PRESYNC;
                        n.cnt = '0;
                        n.pos = POS_W'(HDR_OCTETS);
                    end
                end
                DL_PRESYNC: begin
                    if (at_hec) begin
                        if (!hec_ok) begin
                            n.st  = DL_HUNT;
                            n.cnt = '0;
                        end else if (q.cnt == CNT_W'(PRESYNC_GOOD - 1)) begin
                            n.st  = DL_SYNC;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                DL_SYNC: begin
                    if (at_hec) begin
                        if (hec_ok) begin
                            n.cnt = '0;
                            if (!is_null) begin
                                n.rem = REM_W'(CELL_LEN);
                            end
                        end else if (q.cnt == CNT_W'(SYNC_BAD - 1)) begin
                            n.st  = DL_HUNT;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: n.st = DL_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign cell_valid = q.ov;
    assign cell_data  = q.od;
    assign cell_soc   = q.os;
    assign in_sync    = (q.st == DL_SYNC);

endmodule

// File: rtl/atm_tc_tx.sv
module atm_tc_tx
    import atm_tc_pkg::*;
#(
    parameter int          CELL_LEN  = 53,
    parameter logic [7:0]  IDLE_FILL = 8'h6A,
    parameter logic [7:0]  HEC_COSET = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       octet_en,
    input  logic       atm_avail,
    input  logic [7:0] atm_data,
    output logic       atm_rd,
    output logic       line_valid,
    output logic [7:0] line_data
);

    localparam int POS_W = $clog2(CELL_LEN);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             user;
        logic [7:0]       crc;
        logic             lv;
        logic [7:0]       ld;
    } tx_state_t;

    tx_state_t  q, n;
    logic       slot_user;
    logic       is_hdr;
    logic       is_hec;
    logic [7:0] src;

    always_comb begin
        slot_user = (q.pos == '0) ? atm_avail : q.user;
        is_hdr    = (q.pos < POS_W'(HEC_POS));
        is_hec    = (q.pos == POS_W'(HEC_POS));

        if (is_hec) begin
            src = q.crc ^ HEC_COSET;
        end else if (slot_user) begin
            src = atm_data;
        end else if (is_hdr) begin
            src = NULL_HDR[8*(3 - int'(q.pos)) +: 8];
        end else begin
            src = IDLE_FILL;
        end

        atm_rd = octet_en && slot_user && !is_hec;

        n    = q;
        n.lv = 1'b0;
        if (octet_en) begin
            n.lv   = 1'b1;
            n.ld   = src;
            n.user = slot_user;
            n.pos  = (q.pos == POS_W'(CELL_LEN - 1)) ? '0 : q.pos + 1'b1;
            if (is_hdr) begin
                n.crc = crc8_step((q.pos == '0) ? 8'h00 : q.crc, src);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign line_valid = q.lv;
    assign line_data  = q.ld;

endmodule

// File: rtl/atm_tc_framer.sv
module atm_tc_framer #(
    parameter int          CELL_LEN     = 53,
    parameter int          PRESYNC_GOOD = 6,
    parameter int          SYNC_BAD     = 7,
    parameter logic [7:0]  IDLE_FILL    = 8'h6A,
    parameter logic [7:0]  HEC_COSET    = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in_valid,
    input  logic [7:0] rx_in_data,
    output logic       rx_cell_valid,
    output logic [7:0] rx_cell_data,
    output logic       rx_cell_soc,
    output logic       rx_in_sync,
    input  logic       tx_octet_en,
    input  logic       atm_tx_avail,
    input  logic [7:0] atm_tx_data,
    output logic       atm_tx_rd,
    output logic       tx_line_valid,
    output logic [7:0] tx_line_data
);

    atm_tc_rx #(
        .CELL_LEN     (CELL_LEN),
        .PRESYNC_GOOD (PRESYNC_GOOD),
        .SYNC_BAD     (SYNC_BAD),
        .HEC_COSET    (HEC_COSET)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_in_valid),
        .in_data    (rx_in_data),
        .cell_valid (rx_cell_valid),
        .cell_data  (rx_cell_data),
        .cell_soc   (rx_cell_soc),
        .in_sync    (rx_in_sync)
    );

    atm_tc_tx #(
        .CELL_LEN  (CELL_LEN),
        .IDLE_FILL (IDLE_FILL),
        .HEC_COSET (HEC_COSET)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .octet_en   (tx_octet_en),
        .atm_avail  (atm_tx_avail),
        .atm_data   (atm_tx_data),
        .atm_rd     (atm_tx_rd),
        .line_valid (tx_line_valid),
        .line_data  (tx_line_data)
    );

endmodule

// File: rtl/atm_tc_framer_chk.sv
module atm_tc_framer_chk #(
    parameter int CELL_LEN = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_in_valid,
    input logic       rx_cell_valid,
    input logic       rx_cell_soc,
    input logic       rx_in_sync,
    input logic       tx_octet_en,
    input logic       atm_tx_rd,
    input logic       tx_line_valid
);

    localparam int OC_W = $clog2(CELL_LEN + 1);

    logic [OC_W-1:0] out_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt <= '0;
        end else if (rx_cell_soc) begin
            out_cnt <= OC_W'(1);
        end else if (rx_cell_valid) begin
            out_cnt <= out_cnt + 1'b1;
        end
    end

    AST_SOC_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cell_soc |-> rx_in_sync); // R9
    AST_SOC_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cell_soc |-> rx_cell_valid); // R8
    AST_OUT_PACED_BY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cell_valid |-> $past(rx_in_valid)); // R8
    AST_SOC_ON_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cell_soc |-> (out_cnt == '0 || out_cnt == OC_W'(CELL_LEN))); // R8
    AST_BODY_INSIDE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cell_valid && !rx_cell_soc) |-> (out_cnt != '0 && out_cnt < OC_W'(CELL_LEN))); // R8
    AST_LINE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_octet_en |=> tx_line_valid); // R13
    AST_LINE_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_octet_en |=> !tx_line_valid); // R13
    AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        atm_tx_rd |-> tx_octet_en); // R11

endmodule

bind atm_tc_framer atm_tc_framer_chk #(.CELL_LEN(CELL_LEN)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_in_valid   (rx_in_valid),
    .rx_cell_valid (rx_cell_valid),
    .rx_cell_soc   (rx_cell_soc),
    .rx_in_sync    (rx_in_sync),
    .tx_octet_en   (tx_octet_en),
    .atm_tx_rd     (atm_tx_rd),
    .tx_line_valid (tx_line_valid)
);

// File: tb/atm_tc_framer_tb_top.sv
module atm_tc_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_in_data = 8'h00;
    logic       rx_cell_valid;
    logic [7:0] rx_cell_data;
    logic       rx_cell_soc;
    logic       rx_in_sync;
    logic       tx_octet_en = 1'b0;
    logic       atm_tx_avail = 1'b0;
    logic [7:0] atm_tx_data = 8'h00;
    logic       atm_tx_rd;
    logic       tx_line_valid;
    logic [7:0] tx_line_data;

    int n_checks = 0;
    int n_fail   = 0;
    int gctr     = 0;
    int en_count = 0;
    int line_count = 0;
    bit rd_pend  = 1'b0;

    logic [8:0] rx_exp[$];
    logic [9:0] tx_exp[$];
    logic [7:0] atm_q[$];

    always #10 clk = ~clk;

    atm_tc_framer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_in_valid   (rx_in_valid),
        .rx_in_data    (rx_in_data),
        .rx_cell_valid (rx_cell_valid),
        .rx_cell_data  (rx_cell_data),
        .rx_cell_soc   (rx_cell_soc),
        .rx_in_sync    (rx_in_sync),
        .tx_octet_en   (tx_octet_en),
        .atm_tx_avail  (atm_tx_avail),
        .atm_tx_data   (atm_tx_data),
        .atm_tx_rd     (atm_tx_rd),
        .tx_line_valid (tx_line_valid),
        .tx_line_data  (tx_line_data)
    );

    // header check as remainder of {hdr, 8'h00} modulo 0x107, then coset
    function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
        logic [39:0] r;
        r = {hdr, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (r[i]) r = r ^ (40'h107 << (i - 8));
        end
        return r[7:0] ^ 8'h55;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- receive stimulus ----------------
    task automatic rx_octet(input logic [7:0] d);
        if ((gctr % 7) == 3) begin
            @(negedge clk);
            rx_in_valid = 1'b0;
        end
        gctr++;
        @(negedge clk);
        rx_in_valid = 1'b1;
        rx_in_data  = d;
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic rx_cell(input logic [31:0] hdr, input bit bad, input logic [7:0] fill,
                           input logic [7:0] step, input bit expect_out);
        logic [7:0] c [53];
        for (int i = 0; i < 4; i++) c[i] = hdr[8*(3-i) +: 8];
        c[4] = ref_hec(hdr) ^ (bad ? 8'h03 : 8'h00);
        for (int i = 5; i < 53; i++) c[i] = fill + 8'(step * (i - 5));
        for (int i = 0; i < 53; i++) begin
            if (expect_out) rx_exp.push_back({(i == 0), c[i]});
            rx_octet(c[i]);
        end
    endtask

    // scoreboard monitor for delivered cells
    always @(negedge clk) begin
        if (rst_n && rx_cell_valid) begin
            if (rx_exp.size() == 0) begin
                check(1'b0, "R9", "octet delivered with none expected", int'(rx_cell_data), -1);
            end else begin
                logic [8:0] e;
                e = rx_exp.pop_front();
                check(rx_cell_data == e[7:0], "R8", "delivered octet", int'(rx_cell_data), int'(e[7:0]));
                check(rx_cell_soc == e[8], "R8", "start-of-cell strobe", int'(rx_cell_soc), int'(e[8]));
            end
        end
    end

    // ---------------- transmit stimulus ----------------
    task automatic tx_cycle(input bit en);
        @(negedge clk);
        if (rd_pend) void'(atm_q.pop_front());
        tx_octet_en  = en;
        atm_tx_avail = (atm_q.size() >= 52);
        atm_tx_data  = (atm_q.size() > 0) ? atm_q[0] : 8'h00;
        if (en) en_count++;
        #1;
        rd_pend = atm_tx_rd;
    endtask

    task automatic tx_run(input int n_en);
        int got = 0;
        int k = 0;
        while (got < n_en) begin
            bit en = ((k % 4) != 2);
            tx_cycle(en);
            if (en) got++;
            k++;
        end
    endtask

    task automatic exp_null(input logic [1:0] tag);
        for (int i = 0; i < 4; i++) tx_exp.push_back({tag, NULL_OCT(i)});
        tx_exp.push_back({tag, ref_hec(32'h0000_0001)});
        for (int i = 0; i < 48; i++) tx_exp.push_back({tag, 8'h6A});
    endtask

    function automatic logic [7:0] NULL_OCT(input int i);
        return (i == 3) ? 8'h01 : 8'h00;
    endfunction

    task automatic load_user(input logic [31:0] hdr, input logic [7:0] seed, input logic [1:0] tag);
        for (int i = 0; i < 4; i++) begin
            atm_q.push_back(hdr[8*(3-i) +: 8]);
            tx_exp.push_back({tag, hdr[8*(3-i) +: 8]});
        end
        tx_exp.push_back({tag, ref_hec(hdr)});
        for (int i = 0; i < 48; i++) begin
            atm_q.push_back(seed ^ 8'(i * 5));
            tx_exp.push_back({tag, seed ^ 8'(i * 5)});
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && tx_line_valid) begin
            line_count++;
            if (tx_exp.size() == 0) begin
                check(1'b0, "R13", "line octet with none expected", int'(tx_line_data), -1);
            end else begin
                logic [9:0] e;
                e = tx_exp.pop_front();
                check(tx_line_data == e[7:0],
                      (e[9:8] == 2'd0) ? "R10" : (e[9:8] == 2'd1) ? "R11" : "R12",
                      "line octet", int'(tx_line_data), int'(e[7:0]));
            end
        end
    end

    // watchdog
    initial begin
        #(64'd20 * 64'd200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_in_sync == 1'b0, "R1", "sync during reset", int'(rx_in_sync), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rx_in_sync == 1'b0, "R1", "sync after reset", int'(rx_in_sync), 0);
        check(rx_cell_valid == 1'b0, "R1", "cell valid after reset", int'(rx_cell_valid), 0);
        check(tx_line_valid == 1'b0, "R13", "line valid after reset", int'(tx_line_valid), 0);

        // unaligned start: three filler octets before the first cell (R2)
        for (int i = 0; i < 3; i++) rx_octet(8'h00);
        for (int i = 0; i < 3; i++) rx_cell(32'h0000_0010, 1'b0, 8'h00, 8'h00, 1'b0);
        rx_cell(32'h0000_0010, 1'b1, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b0, "R4", "sync after bad check in confirm", int'(rx_in_sync), 0);
        for (int i = 0; i < 6; i++) rx_cell(32'h0000_0010, 1'b0, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b0, "R3", "sync one check early", int'(rx_in_sync), 0);
        rx_cell(32'h0000_0010, 1'b0, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b1, "R3", "sync after six confirmations", int'(rx_in_sync), 1);

        // delivery of user cells with varied headers (R2, R8)
        rx_cell(32'h1234_5670, 1'b0, 8'h11, 8'h03, 1'b1);
        rx_cell(32'h0ABC_DEF0, 1'b0, 8'hF0, 8'h0D, 1'b1);
        rx_cell(32'hFFFF_FFF2, 1'b0, 8'h6A, 8'h00, 1'b1);
        // null cell dropped (R7)
        rx_cell(32'h0000_0001, 1'b0, 8'h6A, 8'h00, 1'b0);
        check(rx_in_sync == 1'b1, "R7", "sync kept over null cell", int'(rx_in_sync), 1);
        // errored cell dropped (R6)
        rx_cell(32'h1234_5670, 1'b1, 8'h22, 8'h01, 1'b0);
        check(rx_in_sync == 1'b1, "R6", "sync kept over one bad cell", int'(rx_in_sync), 1);
        rx_cell(32'h0001_0020, 1'b0, 8'h33, 8'h07, 1'b1);
        // six bad then good keeps lock (R5)
        for (int i = 0; i < 6; i++) rx_cell(32'h0000_0010, 1'b1, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b1, "R5", "sync after six bad checks", int'(rx_in_sync), 1);
        rx_cell(32'h00A0_0B00, 1'b0, 8'h44, 8'h09, 1'b1);
        // seven bad drops lock (R5)
        for (int i = 0; i < 6; i++) rx_cell(32'h0000_0010, 1'b1, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b1, "R5", "sync after run of six bad", int'(rx_in_sync), 1);
        rx_cell(32'h0000_0010, 1'b1, 8'h00, 8'h00, 1'b0);
        check(rx_in_sync == 1'b0, "R5", "sync after seventh bad", int'(rx_in_sync), 0);
        // good cells while not locked are not delivered (R9)
        rx_cell(32'h0000_0010, 1'b0, 8'h55, 8'h02, 1'b0);
        rx_cell(32'h0000_0010, 1'b0, 8'h55, 8'h02, 1'b0);
        check(rx_in_sync == 1'b0, "R9", "sync after two good cells", int'(rx_in_sync), 0);
        rx_idle();
        repeat (5) @(negedge clk);
        check(rx_exp.size() == 0, "R8", "rx octets still expected", rx_exp.size(), 0);

        // transmit: idle slots (R10)
        exp_null(2'd0);
        exp_null(2'd0);
        tx_run(106);
        // two user cells then an empty slot (R11, R10)
        tx_cycle(1'b0);
        load_user(32'h0123_4560, 8'hA5, 2'd1);
        load_user(32'h0FED_CBA0, 8'h3C, 2'd1);
        exp_null(2'd0);
        tx_run(159);
        // cell arrives inside a slot (R12)
        exp_null(2'd2);
        tx_run(20);
        tx_cycle(1'b0);
        load_user(32'h5555_5550, 8'h0F, 2'd2);
        tx_run(33 + 53);
        repeat (3) tx_cycle(1'b0);
        check(tx_exp.size() == 0, "R11", "line octets still expected", tx_exp.size(), 0);
        check(atm_q.size() == 0, "R11", "ATM octets left unread", atm_q.size(), 0);
        check(line_count == en_count, "R13", "line octets versus enables", line_count, en_count);

        finish_test();
    end

endmodule